// File: doc/BRIEF.md
# SIMD Pairwise Widening Adder

This datapath unit accepts one packed integer vector and sums each neighbouring pair of elements. Every sum lands in a result lane twice as wide as a source element, so the result carries half as many lanes as the operand and the full sum is always kept. Software-visible features such as flags, overflow or saturation do not exist here; the widened lane makes them unnecessary.

Three controls travel with each operand. A 2-bit element-size code picks 8, 16 or 32-bit source elements. A sign bit picks sign or zero extension before the add. A quad bit picks a 128-bit operand, treated as two independent 64-bit halves, or a 64-bit operand taken from the low half. One register stage holds the result, and a valid strobe marks the cycles that carry a new one.

Top module: `pairwise_widen_add`

## Requirements
- R1: Within each 64-bit half, result lane e (width 2×E) equals source element 2e plus source element 2e+1 (width E). Element 0 sits in the least significant bits.
- R2: size_sel encodes the element width E: 2'b00 gives 8 bits, 2'b01 gives 16 bits and 2'b10 gives 32 bits.
- R3: With signed_en=1, elements are sign-extended before the add. Two 8-bit elements of 0x80 give the 16-bit lane 0xFF00.
- R4: With signed_en=0, elements are zero-extended before the add. Two 8-bit elements of 0xFF give the 16-bit lane 0x01FE.
- R5: No sum is truncated. Unsigned 32-bit 0xFFFFFFFF + 0xFFFFFFFF gives 0x1_FFFFFFFE, and signed 0x80000000 + 0x80000000 gives 0xFFFFFFFF_00000000.
- R6: With quad_en=1, bits [127:64] of the result are computed from operand bits [127:64] in the same way as the low half, with no carry between halves.
- R7: With quad_en=0, result bits [127:64] are zero and operand bits [127:64] have no effect.
- R8: size_sel=2'b11 is illegal. The registered illegal_out is 1 and the whole result is zero. For legal codes illegal_out is 0.
- R9: result and illegal_out are loaded on the rising edge at which valid_in is high, and valid_out is high in the cycle after each such edge and low otherwise.
- R10: On an edge with valid_in low, result and illegal_out keep their values, whatever the operand and controls do.
- R11: A synchronous active-high reset clears valid_out, illegal_out and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operand and controls are valid this cycle |
| size_sel | input | 2 | Source element width code |
| signed_en | input | 1 | 1: sign extension, 0: zero extension |
| quad_en | input | 1 | 1: 128-bit operand, 0: 64-bit operand |
| operand | input | 128 | Packed source elements |
| valid_out | output | 1 | A new result is present |
| illegal_out | output | 1 | The held result came from an illegal size code |
| result | output | 128 | Packed widened pair sums |

## Verification
The bound checker watches on every cycle that valid_out follows valid_in by one edge, that the result holds when no operand is taken, that a 64-bit operation leaves the upper half zero, that the illegal code raises the flag and yields zero, and that the lowest unsigned byte pair sums correctly. Only the scoreboard scenarios show that every lane of every size, both extensions and both halves match an independently computed sum. They also cover the extreme values of R3 to R5 and the effect of a reset in the middle of traffic.

// File: rtl/pwa_pkg.sv
`timescale 1ns/1ps
package pwa_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    ESZ_8   = 2'b00,
    ESZ_16  = 2'b01,
    ESZ_32  = 2'b10,
    ESZ_BAD = 2'b11
  } esize_e;

  function automatic logic size_is_legal(input logic [SEL_W-1:0] code, input int num_sizes);
    return int'(code) < num_sizes;
  endfunction
endpackage

// File: rtl/pwa_pair_sum.sv
`timescale 1ns/1ps
// Pair summation for one fixed element width across one half of the vector.
module pwa_pair_sum #(
  parameter int ESIZE  = 8,
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] src,
  input  logic              signed_en,
  output logic [HALF_W-1:0] dst
);
  localparam int RES_W = 2 * ESIZE;
  localparam int PAIRS = HALF_W / RES_W;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [ESIZE-1:0] lo_el, hi_el;
    logic [RES_W-1:0] lo_ext, hi_ext;

    assign lo_el  = src[(2*p)*ESIZE +: ESIZE];
    assign hi_el  = src[(2*p+1)*ESIZE +: ESIZE];
    assign lo_ext = {{ESIZE{signed_en & lo_el[ESIZE-1]}}, lo_el};
    assign hi_ext = {{ESIZE{signed_en & hi_el[ESIZE-1]}}, hi_el};
    assign dst[p*RES_W +: RES_W] = lo_ext + hi_ext;
  end
endmodule

// File: rtl/pwa_out_reg.sv
`timescale 1ns/1ps
// Single output stage: loads on valid_in, holds otherwise.
module pwa_out_reg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_flag,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_flag  <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_data <= d_data;
        q_flag <= d_flag;
      end
    end
  end
endmodule

// File: rtl/pairwise_widen_add.sv
`timescale 1ns/1ps
module pairwise_widen_add #(
  parameter int VEC_W      = 128,
  parameter int HALF_W     = 64,
  parameter int BASE_ESIZE = 8,
  parameter int NUM_SIZES  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_in,
  input  logic [pwa_pkg::SEL_W-1:0] size_sel,
  input  logic                     signed_en,
  input  logic                     quad_en,
  input  logic [VEC_W-1:0]         operand,
  output logic                     valid_out,
  output logic                     illegal_out,
  output logic [VEC_W-1:0]         result
);
  import pwa_pkg::*;

  localparam int NUM_HALVES = VEC_W / HALF_W;

  logic [HALF_W-1:0] sums [NUM_HALVES][NUM_SIZES];
  logic [VEC_W-1:0]  next_res;
  logic              size_ok;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      pwa_pair_sum #(
        .ESIZE  (BASE_ESIZE << k),
        .HALF_W (HALF_W)
      ) u_sum (
        .src       (operand[h*HALF_W +: HALF_W]),
        .signed_en (signed_en),
        .dst       (sums[h][k])
      );
    end
  end

  assign size_ok = size_is_legal(size_sel, NUM_SIZES);

  always_comb begin
    next_res = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      for (int k = 0; k < NUM_SIZES; k++) begin
        if ((size_sel == SEL_W'(k)) && (h == 0 || quad_en))
          next_res[h*HALF_W +: HALF_W] = sums[h][k];
      end
    end
  end

  pwa_out_reg #(
    .DATA_W (VEC_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (valid_in),
    .d_data  (next_res),
    .d_flag  (~size_ok),
    .q_valid (valid_out),
    .q_data  (result),
    .q_flag  (illegal_out)
  );
endmodule

// File: rtl/pwa_checker.sv
`timescale 1ns/1ps
module pwa_checker (
  input logic         clk,
  input logic         rst,
  input logic         valid_in,
  input logic [1:0]   size_sel,
  input logic         signed_en,
  input logic         quad_en,
  input logic [127:0] operand,
  input logic         valid_out,
  input logic         illegal_out,
  input logic [127:0] result
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(result) && $stable(illegal_out)));

  assert_dword_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !quad_en) |=> (result[127:64] == 64'd0));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_in && size_sel == 2'b11) |=> (illegal_out && result == 128'd0));

  assert_legal_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_in && size_sel != 2'b11) |=> !illegal_out);

  assert_byte_pair_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (valid_in && size_sel == 2'b00 && !signed_en) |=>
      (result[15:0] == (16'($past(operand[7:0])) + 16'($past(operand[15:8])))));
endmodule

bind pairwise_widen_add pwa_checker u_pwa_checker (
  .clk         (clk),
  .rst         (rst),
  .valid_in    (valid_in),
  .size_sel    (size_sel),
  .signed_en   (signed_en),
  .quad_en     (quad_en),
  .operand     (operand),
  .valid_out   (valid_out),
  .illegal_out (illegal_out),
  .result      (result)
);

// File: tb/pairwise_widen_add_bench.sv
`timescale 1ns/1ps
module pairwise_widen_add_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_in = 1'b0;
  logic [1:0]   size_sel = 2'b00;
  logic         signed_en = 1'b0;
  logic         quad_en = 1'b0;
  logic [127:0] operand = '0;
  logic         valid_out, illegal_out;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [127:0] res;
    logic         ill;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  logic [127:0] last_res;
  logic         last_ill;

  always #10 clk = ~clk;

  pairwise_widen_add u_pairwise_widen_add (
    .clk(clk), .rst(rst), .valid_in(valid_in), .size_sel(size_sel),
    .signed_en(signed_en), .quad_en(quad_en), .operand(operand),
    .valid_out(valid_out), .illegal_out(illegal_out), .result(result)
  );

  // Independent reference: widened sum of each element pair.
  function automatic logic [127:0] ref_sum(input logic [127:0] op, input logic [1:0] sz,
                                           input logic sg, input logic qd);
    logic [127:0] r = '0;
    int es, lanes;
    logic [63:0] emask, rmask, a, b, s;
    if (sz == 2'b11) return '0;
    es    = 8 << sz;
    lanes = 64 / (2 * es);
    emask = (64'd1 << es) - 64'd1;
    rmask = (es == 32) ? {64{1'b1}} : ((64'd1 << (2 * es)) - 64'd1);
    for (int h = 0; h < (qd ? 2 : 1); h++) begin
      for (int e = 0; e < lanes; e++) begin
        a = 64'(op >> (h * 64 + 2 * e * es)) & emask;
        b = 64'(op >> (h * 64 + (2 * e + 1) * es)) & emask;
        if (sg && a[es-1]) a = a | ~emask;
        if (sg && b[es-1]) b = b | ~emask;
        s = (a + b) & rmask;
        r = r | (128'(s) << (h * 64 + e * 2 * es));
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] op, input logic [1:0] sz, input logic sg,
                      input logic qd, input string tag);
    exp_t it;
    @(negedge clk);
    operand = op; size_sel = sz; signed_en = sg; quad_en = qd; valid_in = 1'b1;
    it.res = ref_sum(op, sz, sg, qd);
    it.ill = (sz == 2'b11);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    valid_in = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: samples 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      if (valid_out) begin
        if (sb_q.size() == 0) begin
          check("R9 valid_out without request", 128'(valid_out), 128'd0);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check(it.tag, result, it.res);
          check({it.tag, " illegal_out R8"}, 128'(illegal_out), 128'(it.ill));
          last_res = it.res;
          last_ill = it.ill;
        end
      end else if (sb_q.size() != 0) begin
        check("R9 valid_out missing", 128'(valid_out), 128'd1);
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid_out", 128'(valid_out), 128'd0);
    check("R11 reset illegal_out", 128'(illegal_out), 128'd0);
    check("R11 reset result", result, 128'd0);
    rst = 1'b0;

    // R3 / R4 byte extremes
    send({112'd0, 16'h8080}, 2'b00, 1'b1, 1'b0, "R3 signed byte 0x80+0x80");
    send({112'd0, 16'hFFFF}, 2'b00, 1'b0, 1'b0, "R4 unsigned byte 0xFF+0xFF");
    // R1 / R2 assorted patterns in every size
    send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 2'b00, 1'b0, 1'b1, "R1 R2 byte unsigned quad");
    send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 2'b00, 1'b1, 1'b1, "R1 R3 byte signed quad");
    send(128'h8000_7FFF_FFFF_0001_1234_F00D_C0DE_9999, 2'b01, 1'b0, 1'b1, "R2 halfword unsigned quad");
    send(128'h8000_7FFF_FFFF_0001_1234_F00D_C0DE_9999, 2'b01, 1'b1, 1'b1, "R2 R3 halfword signed quad");
    send(128'hDEAD_BEEF_0000_0001_7FFF_FFFF_8000_0001, 2'b10, 1'b1, 1'b1, "R2 word signed quad");
    // R5 word extremes
    send({64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b10, 1'b0, 1'b0, "R5 unsigned word max");
    send({64'd0, 64'h8000_0000_8000_0000}, 2'b10, 1'b1, 1'b0, "R5 signed word min");
    // R6 halves independent, R7 upper operand ignored
    send({64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b10, 1'b0, 1'b1, "R6 halves independent");
    send({64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0304_0506_0708}, 2'b00, 1'b0, 1'b0, "R7 dword upper zero");
    // R8 illegal code
    send({128{1'b1}}, 2'b11, 1'b1, 1'b1, "R8 illegal size");
    send(128'h1111_2222_3333_4444_5555_6666_7777_8888, 2'b01, 1'b0, 1'b0, "R8 legal after illegal");
    idle(2);

    // R10: idle cycles with changing inputs leave outputs held
    for (int i = 0; i < 3; i++) begin
      operand = {4{32'hA5A5_0000 + i}}; size_sel = 2'(i); signed_en = ~signed_en; quad_en = ~quad_en;
      @(negedge clk);
      check("R10 result held", result, last_res);
      check("R10 illegal held", 128'(illegal_out), 128'(last_ill));
      check("R9 no valid while idle", 128'(valid_out), 128'd0);
    end

    // R11 reset after traffic
    send(128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000, 2'b11, 1'b0, 1'b1, "R8 illegal before reset");
    idle(2);
    rst = 1'b1;
    @(negedge clk);
    check("R11 mid reset valid_out", 128'(valid_out), 128'd0);
    check("R11 mid reset illegal_out", 128'(illegal_out), 128'd0);
    check("R11 mid reset result", result, 128'd0);
    rst = 1'b0;
    send(128'h7F7F_7F7F_7F7F_7F7F_8181_8181_8181_8181, 2'b00, 1'b1, 1'b1, "R9 first after reset");
    idle(3);

    check("R9 scoreboard drained", 128'(sb_q.size()), 128'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule